// File: doc/BRIEF.md
# Peak-current PWM cycle controller

This block produces the gate-drive pulse train of a peak-current-mode power converter. All timing comes from a digital clock. A free-running period counter starts a new switching cycle whenever it wraps, and the start of each cycle sets a drive flop. The reload length of the counter is dithered by a triangular up/down offset. This spreads the switching energy across a band around the nominal frequency. There is no synchronisation input: the period is fixed by parameters alone.

The analog side of the converter lives outside this block and sends in synchronous comparator flags. Two flags end the on-time: current sense above the feedback setpoint, and current sense above a quarter of the soft-start level. Both flags are ignored for a blanking window that begins at the start of each pulse. Whatever the current does, a duty clamp chosen by a version parameter ends the pulse. Two more flags describe the feedback level and are sampled at the start of each cycle. They select one of three modes:

- normal current-limited pulses;
- a fixed minimum on-time;
- skipping the pulse altogether.

An enable input holds the drive low and restarts both the oscillator phase and the dither sweep.

Top module: `pcm_pwm_ctrl`

## Requirements
- R1: While `rst` is high or `en` is low, `drv` is low one clock edge later. The oscillator phase and the dither offset return to their start values. The first pulse after `en` rises therefore begins on the first clock edge at which `en` is sampled high, and the dither sequence restarts at offset zero.
- R2: Each cycle sets `drv` at its start, unless skip mode applies. The spacing between consecutive rising edges of `drv` equals the length of the cycle that lies between them.
- R3: Cycle k after enable lasts PERIOD + off_k clocks. The offset starts at off_0 = 0 and moves by JIT_STEP per cycle, first upwards. When the next step would pass +JIT_MAX or -JIT_MAX, the direction flips and the offset steps back the other way, so it never leaves the range [-JIT_MAX, +JIT_MAX].
- R4: In normal mode, when `cs_over_fb` is held high from the start of a pulse, the pulse lasts BLANK_CYC+1 clocks (bounded by R7).
- R5: `cs_over_ss` ends the pulse in the same way as `cs_over_fb`. When held high, the pulse lasts BLANK_CYC+1 clocks.
- R6: Current-sense flags that are high only during the first BLANK_CYC clocks of a pulse have no effect. The pulse then runs to the duty clamp.
- R7: No pulse lasts longer than floor(P·N/D) clocks, where P is the length of the current cycle. N/D depends on DUTY_SEL: 0 gives 1/2, 1 gives 4/5, 2 gives 13/20 and 3 gives 19/40. A pulse that no current-sense trip ends lasts exactly that long.
- R8: When `fb_below_min` is high and `fb_below_skip` is low at the start of a cycle, the pulse lasts exactly MIN_ON clocks, or the R7 limit if that is smaller. Current-sense flags are ignored during such a pulse.
- R9: When `fb_below_skip` is high at the start of a cycle, `drv` stays low for the whole cycle. This flag takes priority over `fb_below_min`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, drive is held low and the oscillator restarts |
| cs_over_fb | input | 1 | Current sense is above the feedback-derived setpoint |
| cs_over_ss | input | 1 | Current sense is above one quarter of the soft-start level |
| fb_below_min | input | 1 | Feedback is below the minimum-on-time level |
| fb_below_skip | input | 1 | Feedback is below the skip level |
| drv | output | 1 | Registered gate-drive bit |

## Verification
The assertions check the per-cycle rules on every cycle:

- the drive drops when disabled;
- each start sets the drive unless skip applies, and a skip start leaves it low;
- an on-time never reaches the duty clamp;
- no pulse ends inside the blanking window;
- a minimum-on pulse has exactly its fixed length;
- the dither offset stays inside its band and moves by one step per wrap.

Some behaviour can only be shown by the bench scenarios against lengths it computes itself. These are the exact triangular period sequence with its turn-around points, the restart of that sequence after enable toggles, the ignoring of a trip that ends inside the blanking window, and skip mode taking priority over minimum-on.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_MINON  = 2'd1,
    MODE_SKIP   = 2'd2
  } cyc_mode_t;

  // Duty clamp ratio numerator per version select
  function automatic int duty_num(input int sel);
    case (sel)
      0:       return 1;
      1:       return 4;
      2:       return 13;
      default: return 19;
    endcase
  endfunction

  // Duty clamp ratio denominator per version select
  function automatic int duty_den(input int sel);
    case (sel)
      0:       return 2;
      1:       return 5;
      2:       return 20;
      default: return 40;
    endcase
  endfunction

endpackage

// File: rtl/pwm_jitter_osc.sv
module pwm_jitter_osc #(
  parameter int PERIOD   = 100,
  parameter int JIT_MAX  = 5,
  parameter int JIT_STEP = 1,
  parameter int PW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] per,
  output logic          start
);
  localparam int OW = $clog2(JIT_MAX + JIT_STEP + 1) + 2;

  logic signed [OW-1:0] offs, offs_nx;
  logic                 dir_up, dir_nx;
  logic                 wrap;

  assign per   = PW'(PERIOD + int'(offs));
  assign wrap  = (phase == per - PW'(1));
  assign start = en && (phase == '0);

  generate
    if (JIT_MAX > 0 && JIT_STEP > 0) begin : g_dither
      int up_i, dn_i;
      always_comb begin
        up_i    = int'(offs) + JIT_STEP;
        dn_i    = int'(offs) - JIT_STEP;
        offs_nx = offs;
        dir_nx  = dir_up;
        if (dir_up) begin
          if (up_i > JIT_MAX) begin
            offs_nx = OW'(dn_i);
            dir_nx  = 1'b0;
          end else begin
            offs_nx = OW'(up_i);
          end
        end else begin
          if (dn_i < -JIT_MAX) begin
            offs_nx = OW'(up_i);
            dir_nx  = 1'b1;
          end else begin
            offs_nx = OW'(dn_i);
          end
        end
      end
    end else begin : g_fixed
      always_comb begin
        offs_nx = '0;
        dir_nx  = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase  <= '0;
      offs   <= '0;
      dir_up <= 1'b1;
    end else if (wrap) begin
      phase  <= '0;
      offs   <= offs_nx;
      dir_up <= dir_nx;
    end else begin
      phase  <= phase + PW'(1);
    end
  end

  // R3
  jit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(offs) <= JIT_MAX) && (int'(offs) >= -JIT_MAX));

  generate
    if (JIT_MAX >= JIT_STEP && JIT_STEP > 0) begin : g_step_chk
      // R3
      jit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && en) |=> (!en ||
          int'(per) == int'($past(per)) + JIT_STEP ||
          int'(per) == int'($past(per)) - JIT_STEP));
    end
  endgenerate

endmodule

// File: rtl/pwm_mode_latch.sv
module pwm_mode_latch
  import pwm_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      start,
  input  logic      fb_low,
  input  logic      fb_skip,
  output cyc_mode_t mode
);
  always_ff @(posedge clk) begin
    if (rst || !en)
      mode <= MODE_NORMAL;
    else if (start)
      mode <= fb_skip ? MODE_SKIP : (fb_low ? MODE_MINON : MODE_NORMAL);
  end

  // R9
  skip_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (start && fb_skip) |=> (mode == MODE_SKIP));

endmodule

// File: rtl/pwm_off_ctrl.sv
module pwm_off_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int PW        = 7,
  parameter int BLANK_CYC = 16,
  parameter int MIN_ON    = 24,
  parameter int DUTY_SEL  = 0
) (
  input  logic [PW-1:0] phase,
  input  logic [PW-1:0] per,
  input  cyc_mode_t     mode,
  input  logic          cs_fb,
  input  logic          cs_ss,
  output logic [PW-1:0] max_on,
  output logic          off_req
);
  localparam int NUM = duty_num(DUTY_SEL);
  localparam int DEN = duty_den(DUTY_SEL);

  logic past_blank, clamp_hit, cs_trip, minon_hit;

  assign max_on     = PW'((int'(per) * NUM) / DEN);
  assign clamp_hit  = (phase >= max_on);
  assign past_blank = (phase > PW'(BLANK_CYC));
  assign cs_trip    = past_blank && (cs_fb || cs_ss);
  assign minon_hit  = (phase >= PW'(MIN_ON));

  always_comb begin
    case (mode)
      MODE_MINON: off_req = clamp_hit || minon_hit;
      default:    off_req = clamp_hit || cs_trip;
    endcase
  end

endmodule

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int PERIOD    = 100,
  parameter int JIT_MAX   = 5,
  parameter int JIT_STEP  = 1,
  parameter int BLANK_CYC = 16,
  parameter int MIN_ON    = 24,
  parameter int DUTY_SEL  = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cs_over_fb,
  input  logic cs_over_ss,
  input  logic fb_below_min,
  input  logic fb_below_skip,
  output logic drv
);
  localparam int PW = $clog2(PERIOD + JIT_MAX + 1) + 1;

  logic [PW-1:0] phase, per, max_on;
  logic          start, off_req;
  cyc_mode_t     mode;

  pwm_jitter_osc #(
    .PERIOD(PERIOD), .JIT_MAX(JIT_MAX), .JIT_STEP(JIT_STEP), .PW(PW)
  ) u_osc (
    .clk(clk), .rst(rst), .en(en),
    .phase(phase), .per(per), .start(start)
  );

  pwm_mode_latch u_mode (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .fb_low(fb_below_min), .fb_skip(fb_below_skip), .mode(mode)
  );

  pwm_off_ctrl #(
    .PW(PW), .BLANK_CYC(BLANK_CYC), .MIN_ON(MIN_ON), .DUTY_SEL(DUTY_SEL)
  ) u_off (
    .phase(phase), .per(per), .mode(mode),
    .cs_fb(cs_over_fb), .cs_ss(cs_over_ss),
    .max_on(max_on), .off_req(off_req)
  );

  // Drive flop: set at cycle start, cleared by the off request
  always_ff @(posedge clk) begin
    if (rst || !en)
      drv <= 1'b0;
    else if (start)
      drv <= !fb_below_skip;
    else if (drv && off_req)
      drv <= 1'b0;
  end

  // On-time tracker used only by the checks below
  logic [PW-1:0] on_len;
  always_ff @(posedge clk) begin
    if (rst || !drv)
      on_len <= '0;
    else
      on_len <= on_len + PW'(1);
  end

  // R1
  dis_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drv);

  // R2
  cyc_set_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !fb_below_skip) |=> drv);

  // R9
  skip_low_chk: assert property (@(posedge clk) disable iff (rst)
    (start && fb_below_skip) |=> !drv);

  // R7
  max_duty_chk: assert property (@(posedge clk) disable iff (rst)
    drv |-> (on_len < max_on));

  // R6
  blank_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv) && $past(en)) |-> (int'($past(on_len)) >= BLANK_CYC));

  // R8
  minon_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv) && $past(en) && $past(mode) == MODE_MINON) |->
      (int'($past(on_len)) + 1 ==
       ((MIN_ON < int'($past(max_on))) ? MIN_ON : int'($past(max_on)))));

endmodule

// File: tb/tb_pcm_pwm_ctrl.sv
module tb_pcm_pwm_ctrl;
  localparam int PERIOD    = 100;
  localparam int JIT_MAX   = 5;
  localparam int JIT_STEP  = 1;
  localparam int BLANK_CYC = 16;
  localparam int MIN_ON    = 24;
  localparam int DUTY_SEL  = 0;
  localparam int WD_LIMIT  = 150000;

  logic clk = 1'b0;
  logic rst, en, cs_over_fb, cs_over_ss, fb_below_min, fb_below_skip;
  logic drv;

  always #5 clk = ~clk;

  pcm_pwm_ctrl #(
    .PERIOD(PERIOD), .JIT_MAX(JIT_MAX), .JIT_STEP(JIT_STEP),
    .BLANK_CYC(BLANK_CYC), .MIN_ON(MIN_ON), .DUTY_SEL(DUTY_SEL)
  ) dut (
    .clk(clk), .rst(rst), .en(en),
    .cs_over_fb(cs_over_fb), .cs_over_ss(cs_over_ss),
    .fb_below_min(fb_below_min), .fb_below_skip(fb_below_skip),
    .drv(drv)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wq[$];
  string wtag[$];
  int pq[$];
  string ptag[$];
  int rises = 0;
  int cyc = 0;
  int wlen = 0;
  int last_rise = 0;
  bit lr_ok = 0;
  bit pd = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R7 ratio, written from the requirement
  function automatic int clamp_len(input int p);
    case (DUTY_SEL)
      0: return (p * 1) / 2;
      1: return (p * 4) / 5;
      2: return (p * 13) / 20;
      default: return (p * 19) / 40;
    endcase
  endfunction

  // R3 period sequence
  function automatic int period_k(input int k);
    int o = 0;
    bit up = 1;
    for (int i = 0; i < k; i++) begin
      if (up) begin
        if (o + JIT_STEP > JIT_MAX) begin o = o - JIT_STEP; up = 0; end
        else o = o + JIT_STEP;
      end else begin
        if (o - JIT_STEP < -JIT_MAX) begin o = o + JIT_STEP; up = 1; end
        else o = o - JIT_STEP;
      end
    end
    return PERIOD + o;
  endfunction

  // Monitor: pops expected items as the design produces pulses
  always @(negedge clk) begin
    if (rst) begin
      pd = 0; wlen = 0; lr_ok = 0;
    end else begin
      cyc++;
      if (drv && !pd) begin
        rises++;
        if (lr_ok && en) begin
          if (pq.size() == 0) check(0, "R2 unexpected rise", cyc - last_rise, -1);
          else begin
            int e;
            string t;
            e = pq.pop_front();
            t = ptag.pop_front();
            check((cyc - last_rise) == e, t, cyc - last_rise, e);
          end
        end
        last_rise = cyc;
        lr_ok = 1;
      end
      if (drv) wlen++;
      else if (pd) begin
        if (en) begin
          if (wq.size() == 0) check(0, "R2 unexpected pulse", wlen, -1);
          else begin
            int e;
            string t;
            e = wq.pop_front();
            t = wtag.pop_front();
            check(wlen == e, t, wlen, e);
          end
        end
        wlen = 0;
      end
      if (!en) lr_ok = 0;
      pd = drv;
    end
  end

  // Watchdog
  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step_in();
    @(posedge clk);
    #2;
  endtask

  task automatic drain();
    while (wq.size() != 0) step_in();
    en = 1'b0;
    repeat (4) step_in();
    check(pq.size() == 0, "R2 leftover periods", pq.size(), 0);
  endtask

  // Driver: set flags, enable, push expected pulse widths and periods
  task automatic run_case(input string tag, input bit fl, input bit cf,
                          input bit cs_s, input int n);
    int p, mo, e;
    fb_below_min = fl; fb_below_skip = 1'b0;
    cs_over_fb = cf; cs_over_ss = cs_s;
    for (int k = 0; k < n; k++) begin
      p  = period_k(k);
      mo = clamp_len(p);
      if (fl) e = (MIN_ON < mo) ? MIN_ON : mo;
      else if (cf || cs_s) e = (BLANK_CYC + 1 < mo) ? BLANK_CYC + 1 : mo;
      else e = mo;
      wq.push_back(e);
      wtag.push_back(tag);
      if (k < n - 1) begin
        pq.push_back(p);
        ptag.push_back("R3 period");
      end
    end
    en = 1'b1;
    drain();
  endtask

  initial begin
    rst = 1'b1; en = 1'b0;
    cs_over_fb = 0; cs_over_ss = 0; fb_below_min = 0; fb_below_skip = 0;
    repeat (3) @(negedge clk);
    check(drv == 1'b0, "R1 reset drive", drv, 0);
    step_in();
    rst = 1'b0;
    repeat (3) step_in();

    // R2 R3 R7: free run across both dither turn-arounds
    run_case("R7 clamp width", 0, 0, 0, 25);

    // R4 / R5: trips held from the start of the pulse
    run_case("R4 cs_fb width", 0, 1, 0, 6);
    run_case("R5 cs_ss width", 0, 0, 1, 6);

    // R6: trip confined to the blanking window
    cs_over_fb = 0; cs_over_ss = 0; fb_below_min = 0; fb_below_skip = 0;
    wq.push_back(clamp_len(PERIOD));
    wtag.push_back("R6 blank ignores trip");
    en = 1'b1;
    @(negedge clk);
    while (!drv) @(negedge clk);
    step_in();
    cs_over_fb = 1'b1;
    repeat (BLANK_CYC - 4) step_in();
    cs_over_fb = 1'b0;
    drain();

    // R8: minimum on-time, with and without a trip present
    run_case("R8 min-on width", 1, 0, 0, 5);
    run_case("R8 min-on ignores cs", 1, 1, 1, 4);

    // R9: skip, alone and together with min-on
    begin
      int r0;
      fb_below_skip = 1'b1; fb_below_min = 1'b0; cs_over_fb = 0; cs_over_ss = 0;
      r0 = rises;
      en = 1'b1;
      repeat (4 * PERIOD) step_in();
      check(rises == r0, "R9 skip no pulse", rises - r0, 0);
      check(drv == 1'b0, "R9 skip drive low", drv, 0);
      en = 1'b0;
      step_in();
      fb_below_min = 1'b1;
      r0 = rises;
      en = 1'b1;
      repeat (3 * PERIOD) step_in();
      check(rises == r0, "R9 skip over min-on", rises - r0, 0);
      en = 1'b0;
      fb_below_skip = 1'b0; fb_below_min = 1'b0;
      repeat (3) step_in();
    end

    // R1: disable in the middle of a pulse
    en = 1'b1;
    @(negedge clk);
    while (!drv) @(negedge clk);
    repeat (3) step_in();
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(drv == 1'b0, "R1 disable drops drive", drv, 0);
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (drv) hi++;
      end
      check(hi == 0, "R1 stays low when disabled", hi, 0);
    end
    step_in();

    // R1: sequence restarts at offset zero after re-enable
    run_case("R1 restart width", 0, 0, 0, 4);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule